// File: doc/BRIEF.md
# Data-Space Router with Core Port Registers

This block sits between a microcontroller core's load/store stage and the places a byte can live. Each request carries a byte address, or a port number when it comes from a direct port instruction. The block sends it to one of three targets: the general register file, the I/O port window, or external data memory. Inside the I/O window, eight ports are served by registers held in the block. These are four extended-address page registers, an indirect-jump extension register, the two stack-pointer bytes and the status register. Every other port goes to an external byte bus.

Accesses to the register file and to the core registers complete in the cycle they are presented, and read data is returned combinationally. Ports outside the core set, and all data memory, go out on a valid/ready byte bus. The request is held stalled until that bus answers. Writes to some core registers are gated by feature-enable inputs, so one block can serve core variants with different address widths.

Top module: `dsr_router`

## Requirements
- R1: In data mode (`req_port`=0), an address below 32 selects register-file entry `addr[4:0]`. A read returns `rf_rdata`, a write pulses `rf_we` with `rf_wdata` equal to `req_wdata`, and `req_ready` is high in the same cycle.
- R2: In data mode, addresses 32 to 32+NUM_IO-1 select I/O port `addr-32`. In port mode (`req_port`=1), the port is `addr[5:0]` and the upper address bits are ignored.
- R3: In data mode, addresses at or above 32+NUM_IO go to the external bus at `ext_addr` = DATA_BASE + addr.
- R4: An I/O port outside 0x38..0x3F goes to the external bus at `ext_addr` = IO_BASE + port, with `ext_write` and `ext_wdata` taken from the request.
- R5: While an external access is pending, `ext_valid` stays high and `req_ready` is low. `req_ready` follows `ext_ready`, and read data comes from `ext_rdata`.
- R6: Ports 0x38, 0x39, 0x3A and 0x3B are page registers D, X, Y and Z, gated by `feat_en[0]`, `[1]`, `[2]` and `[3]` respectively. An enabled write places the byte in bits 23:16 of the register's output, with bits 15:0 zero. A disabled write leaves the register unchanged. A read returns bits 23:16.
- R7: Port 0x3C is the jump-extension register. Its byte sits in bits 23:16 of `jmp_ext`, and a write to it is always accepted.
- R8: Port 0x3D reads and writes `stk_ptr[7:0]`. A write leaves `stk_ptr[15:8]` unchanged.
- R9: Port 0x3E reads `stk_ptr[15:8]`. A write updates only that byte, and only when `feat_en[4]` is set.
- R10: Port 0x3F reads and writes the 8-bit `status` register.
- R11: After reset, all page registers, `jmp_ext`, `stk_ptr` and `status` are zero.
- R12: Exactly one target is chosen per request. Register-file and core-port accesses never raise `ext_valid`, and `rf_we` is raised only by register-file writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| feat_en | input | 5 | Write enables: bits 3:0 for page registers D, X, Y, Z; bit 4 for the wide stack pointer |
| req_valid | input | 1 | Request present |
| req_port | input | 1 | 1: address is an I/O port number; 0: data-space address |
| req_write | input | 1 | 1 for a store |
| req_addr | input | ADDR_W | Byte address or port number |
| req_wdata | input | 8 | Store data |
| req_ready | output | 1 | Request completes in this cycle |
| req_rdata | output | 8 | Load data |
| rf_we | output | 1 | Register-file write strobe |
| rf_idx | output | 5 | Register-file index |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | input | 8 | Register-file read data (combinational) |
| ext_valid | output | 1 | External bus request |
| ext_write | output | 1 | External bus write |
| ext_addr | output | EXT_W | External bus byte address |
| ext_wdata | output | 8 | External bus write data |
| ext_ready | input | 1 | External bus accepts or returns data |
| ext_rdata | input | 8 | External bus read data |
| page_d | output | 24 | Page register D |
| page_x | output | 24 | Page register X |
| page_y | output | 24 | Page register Y |
| page_z | output | 24 | Page register Z |
| jmp_ext | output | 24 | Indirect-jump extension |
| stk_ptr | output | 16 | Stack pointer |
| status | output | 8 | Status register |

## Verification
Every data address from 0 to 127 is read in turn. This separates the register-file, core-port, forwarded-port and memory regions at each boundary: 31/32, 87/88, 95/96. Every port number is read in port mode with junk in the upper address bits, which shows the mode switch and that those bits are ignored.

All 32 feature-enable patterns are crossed with a write to each of the eight core ports, and every register is read back afterwards. This separates the enable bit of each gated register from the others and shows that the ungated registers always take the write. External accesses are given varying numbers of wait cycles, which shows the stall and the data source. High memory addresses and register-file writes complete the set.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef enum logic [1:0] {
    RGN_GPR = 2'd0,
    RGN_IO  = 2'd1,
    RGN_MEM = 2'd2
  } rgn_e;

  // Port window served by the block itself; slot = port[2:0]
  localparam int unsigned CORE_WIN_LO = 32'h38;
  localparam int unsigned CORE_WIN_HI = 32'h3F;

  localparam logic [2:0] SLOT_JMP  = 3'd4;
  localparam logic [2:0] SLOT_SPL  = 3'd5;
  localparam logic [2:0] SLOT_SPH  = 3'd6;
  localparam logic [2:0] SLOT_SREG = 3'd7;

  function automatic logic in_core_window(input int unsigned port);
    return (port >= CORE_WIN_LO) && (port <= CORE_WIN_HI);
  endfunction

  // Byte registers are presented in bits 23:16 of a 24-bit word
  function automatic logic [23:0] page_word(input logic [7:0] b);
    return {b, 16'h0000};
  endfunction

  function automatic logic [23:0] ext_map(input logic [23:0] base,
                                          input logic [23:0] offset);
    return base + offset;
  endfunction

endpackage

// File: rtl/dsr_decode.sv
module dsr_decode
  import dsr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_GPR = 32,
  parameter int NUM_IO  = 64,
  parameter int PORT_W  = 6
) (
  input  logic              port_mode,
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              rgn,
  output logic [PORT_W-1:0] port_num,
  output logic              core_hit
);

  logic [31:0] a32;
  assign a32 = 32'(addr);

  always_comb begin
    rgn      = RGN_MEM;
    port_num = '0;
    if (port_mode) begin
      rgn      = RGN_IO;
      port_num = addr[PORT_W-1:0];
    end else if (a32 < 32'(NUM_GPR)) begin
      rgn = RGN_GPR;
    end else if (a32 < 32'(NUM_GPR + NUM_IO)) begin
      rgn      = RGN_IO;
      port_num = PORT_W'(a32 - 32'(NUM_GPR));
    end
  end

  assign core_hit = (rgn == RGN_IO) && in_core_window(32'(port_num));

endmodule

// File: rtl/dsr_core_regs.sv
module dsr_core_regs
  import dsr_pkg::*;
#(
  parameter int NUM_PAGE = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PAGE-1:0]       page_en,
  input  logic                      sp_wide_en,
  input  logic                      we,
  input  logic [2:0]                slot,
  input  logic [7:0]                wdata,
  output logic [7:0]                rdata,
  output logic [NUM_PAGE-1:0][23:0] page_words,
  output logic [23:0]               jmp_ext,
  output logic [15:0]               stk_ptr,
  output logic [7:0]                status
);

  localparam int SEL_W = $clog2(NUM_PAGE);

  logic [NUM_PAGE-1:0][7:0] page_bytes;
  logic [7:0]               jmp_q;
  logic [7:0]               spl_q;
  logic [7:0]               sph_q;
  logic [7:0]               sreg_q;

  for (genvar g = 0; g < NUM_PAGE; g++) begin : gen_page
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (we && (slot == 3'(g)) && page_en[g]) begin
        q <= wdata;
      end
    end
    assign page_bytes[g] = q;
    assign page_words[g] = page_word(q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jmp_q  <= '0;
      spl_q  <= '0;
      sph_q  <= '0;
      sreg_q <= '0;
    end else if (we) begin
      if (slot == SLOT_JMP)                 jmp_q  <= wdata;
      if (slot == SLOT_SPL)                 spl_q  <= wdata;
      if (slot == SLOT_SPH && sp_wide_en)   sph_q  <= wdata;
      if (slot == SLOT_SREG)                sreg_q <= wdata;
    end
  end

  always_comb begin
    case (slot)
      SLOT_JMP:  rdata = jmp_q;
      SLOT_SPL:  rdata = spl_q;
      SLOT_SPH:  rdata = sph_q;
      SLOT_SREG: rdata = sreg_q;
      default:   rdata = page_bytes[slot[SEL_W-1:0]];
    endcase
  end

  assign jmp_ext = page_word(jmp_q);
  assign stk_ptr = {sph_q, spl_q};
  assign status  = sreg_q;

endmodule

// File: rtl/dsr_router.sv
module dsr_router
  import dsr_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          NUM_GPR   = 32,
  parameter int          NUM_IO    = 64,
  parameter int          EXT_W     = 24,
  parameter logic [23:0] IO_BASE   = 24'h100000,
  parameter logic [23:0] DATA_BASE = 24'h200000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [4:0]                  feat_en,
  input  logic                        req_valid,
  input  logic                        req_port,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [7:0]                  req_wdata,
  output logic                        req_ready,
  output logic [7:0]                  req_rdata,
  output logic                        rf_we,
  output logic [$clog2(NUM_GPR)-1:0]  rf_idx,
  output logic [7:0]                  rf_wdata,
  input  logic [7:0]                  rf_rdata,
  output logic                        ext_valid,
  output logic                        ext_write,
  output logic [EXT_W-1:0]            ext_addr,
  output logic [7:0]                  ext_wdata,
  input  logic                        ext_ready,
  input  logic [7:0]                  ext_rdata,
  output logic [23:0]                 page_d,
  output logic [23:0]                 page_x,
  output logic [23:0]                 page_y,
  output logic [23:0]                 page_z,
  output logic [23:0]                 jmp_ext,
  output logic [15:0]                 stk_ptr,
  output logic [7:0]                  status
);

  localparam int PORT_W   = $clog2(NUM_IO);
  localparam int GPR_W    = $clog2(NUM_GPR);
  localparam int NUM_PAGE = 4;

  rgn_e              rgn;
  logic [PORT_W-1:0] port_num;
  logic              core_hit;

  // Named events for the checker
  logic              hit_gpr;
  logic              hit_core;
  logic              hit_ext;
  logic              core_we;
  logic [2:0]        core_slot;
  logic [7:0]        core_rdata;

  logic [NUM_PAGE-1:0][23:0] page_words;

  dsr_decode #(
    .ADDR_W (ADDR_W),
    .NUM_GPR(NUM_GPR),
    .NUM_IO (NUM_IO),
    .PORT_W (PORT_W)
  ) u_decode (
    .port_mode(req_port),
    .addr     (req_addr),
    .rgn      (rgn),
    .port_num (port_num),
    .core_hit (core_hit)
  );

  assign hit_gpr   = (rgn == RGN_GPR);
  assign hit_core  = core_hit;
  assign hit_ext   = (rgn == RGN_MEM) || ((rgn == RGN_IO) && !core_hit);
  assign core_we   = req_valid && req_write && hit_core;
  assign core_slot = port_num[2:0];

  dsr_core_regs #(
    .NUM_PAGE(NUM_PAGE)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .page_en   (feat_en[NUM_PAGE-1:0]),
    .sp_wide_en(feat_en[4]),
    .we        (core_we),
    .slot      (core_slot),
    .wdata     (req_wdata),
    .rdata     (core_rdata),
    .page_words(page_words),
    .jmp_ext   (jmp_ext),
    .stk_ptr   (stk_ptr),
    .status    (status)
  );

  assign page_d = page_words[0];
  assign page_x = page_words[1];
  assign page_y = page_words[2];
  assign page_z = page_words[3];

  // Register-file side
  assign rf_we    = req_valid && req_write && hit_gpr;
  assign rf_idx   = req_addr[GPR_W-1:0];
  assign rf_wdata = req_wdata;

  // External bus side
  logic [23:0] ext_full;
  always_comb begin
    if (rgn == RGN_MEM) ext_full = ext_map(DATA_BASE, 24'(req_addr));
    else                ext_full = ext_map(IO_BASE, 24'(port_num));
  end

  assign ext_valid = req_valid && hit_ext;
  assign ext_write = req_write;
  assign ext_addr  = EXT_W'(ext_full);
  assign ext_wdata = req_wdata;

  // Response
  assign req_ready = hit_ext ? ext_ready : 1'b1;

  always_comb begin
    if (hit_gpr)       req_rdata = rf_rdata;
    else if (hit_core) req_rdata = core_rdata;
    else               req_rdata = ext_rdata;
  end

endmodule

// File: rtl/dsr_router_chk.sv
module dsr_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  feat_en,
  input logic        req_valid,
  input logic [7:0]  req_wdata,
  input logic        req_ready,
  input logic        ext_valid,
  input logic        ext_ready,
  input logic        rf_we,
  input logic        hit_gpr,
  input logic        hit_core,
  input logic        hit_ext,
  input logic        core_we,
  input logic [2:0]  core_slot,
  input logic [23:0] page_d,
  input logic [23:0] jmp_ext,
  input logic [15:0] stk_ptr,
  input logic [7:0]  status
);

  assert_one_target_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({hit_gpr, hit_core, hit_ext}) == 1);

  assert_no_rf_on_ext_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> !rf_we);

  assert_int_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit_ext) |-> (req_ready && !ext_valid));

  assert_ext_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_ext) |-> (ext_valid && (req_ready == ext_ready)));

  assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_we && core_slot == 3'd0) |=> $stable(page_d));

  assert_jmp_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && core_slot == 3'd4) |=> jmp_ext[23:16] == $past(req_wdata));

  assert_sp_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && core_slot == 3'd5) |=>
      (stk_ptr[7:0] == $past(req_wdata)) && (stk_ptr[15:8] == $past(stk_ptr[15:8])));

  assert_sp_high_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && core_slot == 3'd6 && !feat_en[4]) |=> $stable(stk_ptr));

  assert_status_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && core_slot == 3'd7) |=> status == $past(req_wdata));

endmodule

bind dsr_router dsr_router_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .feat_en  (feat_en),
  .req_valid(req_valid),
  .req_wdata(req_wdata),
  .req_ready(req_ready),
  .ext_valid(ext_valid),
  .ext_ready(ext_ready),
  .rf_we    (rf_we),
  .hit_gpr  (hit_gpr),
  .hit_core (hit_core),
  .hit_ext  (hit_ext),
  .core_we  (core_we),
  .core_slot(core_slot),
  .page_d   (page_d),
  .jmp_ext  (jmp_ext),
  .stk_ptr  (stk_ptr),
  .status   (status)
);

// File: tb/dsr_router_test.sv
`timescale 1ns/1ps
module dsr_router_test;

  localparam logic [23:0] IO_B = 24'h100000;
  localparam logic [23:0] DM_B = 24'h200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  feat_en;
  logic        req_valid, req_port, req_write;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready;
  logic [7:0]  req_rdata;
  logic        rf_we;
  logic [4:0]  rf_idx;
  logic [7:0]  rf_wdata, rf_rdata;
  logic        ext_valid, ext_write;
  logic [23:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic        ext_ready;
  logic [7:0]  ext_rdata;
  logic [23:0] page_d, page_x, page_y, page_z, jmp_ext;
  logic [15:0] stk_ptr;
  logic [7:0]  status;

  always #4 clk = ~clk;

  dsr_router #(.IO_BASE(IO_B), .DATA_BASE(DM_B)) uut (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en),
    .req_valid(req_valid), .req_port(req_port), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .ext_valid(ext_valid), .ext_write(ext_write), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_ready(ext_ready), .ext_rdata(ext_rdata),
    .page_d(page_d), .page_x(page_x), .page_y(page_y), .page_z(page_z),
    .jmp_ext(jmp_ext), .stk_ptr(stk_ptr), .status(status)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // model of the core-owned bytes: 0..3 pages D,X,Y,Z, 4 jump extension
  logic [7:0]  m_pg [5];
  logic [15:0] m_sp;
  logic [7:0]  m_sr;

  // observations
  logic        o_ev, o_ew, o_rfwe, o_ready, o_stall_ok;
  logic [23:0] o_ea;
  logic [7:0]  o_ewd, o_rfwd, o_rdata;
  logic [4:0]  o_rfidx;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] f_rf(input logic [4:0] i);
    return 8'hA5 ^ {i, 3'b101};
  endfunction

  function automatic logic [7:0] f_ext(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] mread(input int s);
    case (s)
      5: return m_sp[7:0];
      6: return m_sp[15:8];
      7: return m_sr;
      default: return m_pg[s];
    endcase
  endfunction

  task automatic access(input bit pm, input bit wr, input logic [15:0] a,
                        input logic [7:0] d, input int waits);
    @(negedge clk);
    req_valid = 1; req_port = pm; req_write = wr; req_addr = a; req_wdata = d;
    ext_ready = 0; ext_rdata = 8'h00; rf_rdata = f_rf(a[4:0]);
    #1;
    o_ev = ext_valid; o_ew = ext_write; o_ea = ext_addr; o_ewd = ext_wdata;
    o_rfwe = rf_we; o_rfidx = rf_idx; o_rfwd = rf_wdata;
    o_stall_ok = 1;
    if (ext_valid) begin
      for (int i = 0; i < waits; i++) begin
        if (req_ready !== 1'b0) o_stall_ok = 0;
        @(negedge clk); #1;
        if (ext_valid !== 1'b1 || ext_addr !== o_ea) o_stall_ok = 0;
      end
      ext_ready = 1; ext_rdata = f_ext(ext_addr);
      #1;
    end
    o_ready = req_ready; o_rdata = req_rdata;
    @(posedge clk); #1;
    req_valid = 0; ext_ready = 0;
  endtask

  // access plus checks against an arithmetic model of the routing rules
  task automatic run(input bit pm, input bit wr, input logic [15:0] a,
                     input logic [7:0] d, input int waits);
    int port;
    int kind; // 0 gpr, 1 io, 2 mem
    port = 0;
    if (pm) begin kind = 1; port = int'(a[5:0]); end
    else if (a < 32) kind = 0;
    else if (a < 96) begin kind = 1; port = int'(a) - 32; end
    else kind = 2;
    access(pm, wr, a, d, waits);
    if (kind == 0) begin
      chk("R1 ready", 32'(o_ready), 1);
      chk("R1 rf_we", 32'(o_rfwe), 32'(wr));
      chk("R1 rf_idx", 32'(o_rfidx), 32'(a[4:0]));
      if (wr) chk("R1 rf_wdata", 32'(o_rfwd), 32'(d));
      else    chk("R1 rdata", 32'(o_rdata), 32'(f_rf(a[4:0])));
      chk("R12 no ext on gpr", 32'(o_ev), 0);
    end else if (kind == 1 && port >= 'h38) begin
      chk("R12 no ext on core", 32'(o_ev), 0);
      chk("R12 no rf_we on core", 32'(o_rfwe), 0);
      chk("R2 core ready", 32'(o_ready), 1);
      if (!wr) chk("R6-R10 core read", 32'(o_rdata), 32'(mread(port - 'h38)));
      else begin
        case (port - 'h38)
          0, 1, 2, 3: if (feat_en[port - 'h38]) m_pg[port - 'h38] = d;
          4: m_pg[4] = d;
          5: m_sp[7:0] = d;
          6: if (feat_en[4]) m_sp[15:8] = d;
          default: m_sr = d;
        endcase
      end
    end else begin
      if (kind == 1) chk("R2 R4 io ext addr", 32'(o_ea), 32'(IO_B + 24'(port)));
      else           chk("R3 mem ext addr", 32'(o_ea), 32'(DM_B + 24'(a)));
      chk("R4 ext_valid", 32'(o_ev), 1);
      chk("R4 ext_write", 32'(o_ew), 32'(wr));
      chk("R5 stall", 32'(o_stall_ok), 1);
      chk("R5 ready", 32'(o_ready), 1);
      chk("R12 no rf_we on ext", 32'(o_rfwe), 0);
      if (wr) chk("R4 ext_wdata", 32'(o_ewd), 32'(d));
      else    chk("R5 ext rdata", 32'(o_rdata), 32'(f_ext(o_ea)));
    end
  endtask

  task automatic chk_outputs(input string tag);
    chk({"R6 page_d ", tag}, 32'(page_d), 32'({m_pg[0], 16'h0}));
    chk({"R6 page_x ", tag}, 32'(page_x), 32'({m_pg[1], 16'h0}));
    chk({"R6 page_y ", tag}, 32'(page_y), 32'({m_pg[2], 16'h0}));
    chk({"R6 page_z ", tag}, 32'(page_z), 32'({m_pg[3], 16'h0}));
    chk({"R7 jmp_ext ", tag}, 32'(jmp_ext), 32'({m_pg[4], 16'h0}));
    chk({"R8 R9 stk_ptr ", tag}, 32'(stk_ptr), 32'(m_sp));
    chk({"R10 status ", tag}, 32'(status), 32'(m_sr));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; feat_en = 5'h1F;
    req_valid = 0; req_port = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    rf_rdata = '0; ext_ready = 0; ext_rdata = '0;
    for (int i = 0; i < 5; i++) m_pg[i] = 8'h00;
    m_sp = 16'h0000; m_sr = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset values
    chk_outputs("R11 reset");
    chk("R11 idle ext_valid", 32'(ext_valid), 0);
    rst_n = 1;

    // load distinct values into all core ports
    for (int s = 0; s < 8; s++) run(1'b1, 1'b1, 16'(32'h38 + s), 8'(8'h11 * (s + 1)), 0);
    chk_outputs("preload");

    // data-space read sweep across all region boundaries
    for (int a = 0; a < 128; a++) run(1'b0, 1'b0, 16'(a), 8'h00, a % 3);

    // port-mode read sweep, upper address bits ignored (R2)
    for (int p = 0; p < 64; p++) run(1'b1, 1'b0, 16'(p) | 16'hA5C0, 8'h00, p % 2);

    // high memory addresses, long waits (R3, R5)
    run(1'b0, 1'b0, 16'hFFFF, 8'h00, 4);
    run(1'b0, 1'b0, 16'h8000, 8'h00, 5);
    run(1'b0, 1'b1, 16'h1234, 8'h6E, 2);

    // feature-gate sweep over every enable pattern and every core port
    for (int f = 0; f < 32; f++) begin
      feat_en = 5'(f);
      for (int s = 0; s < 8; s++) begin
        logic [7:0] v;
        v = 8'(f * 29 + s * 13 + 1);
        if (((f + s) % 2) == 1) run(1'b1, 1'b1, 16'(32'h38 + s), v, 0);
        else                    run(1'b0, 1'b1, 16'(32'h58 + s), v, 0);
      end
      chk_outputs("gate sweep");
      for (int s = 0; s < 8; s++) run(1'b0, 1'b0, 16'(32'h58 + s), 8'h00, 0);
    end

    // writes elsewhere leave core registers untouched (R12)
    feat_en = 5'h1F;
    run(1'b0, 1'b1, 16'd0,  8'hC1, 0);
    run(1'b0, 1'b1, 16'd31, 8'hC2, 0);
    run(1'b1, 1'b1, 16'h0000, 8'hC3, 1);
    run(1'b1, 1'b1, 16'h0037, 8'hC4, 3);
    run(1'b0, 1'b1, 16'd87, 8'hC5, 1);
    chk_outputs("R12 after other writes");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule